// File: doc/BRIEF.md
# Masked Trigger Word Comparator

This block watches a sampled data word made of several 8-bit channel banks and raises a trigger when the word matches a programmed pattern. Every compare bit has its own care flag, so any bit can be made don't-care. The pattern, the care flags and three term-enable flags are loaded through a two-wire serial port (a clock line and a data line) into one internal shift chain. The chain's last bit is presented on a serial output, so further configuration registers can be daisy-chained after it.

The comparator result is combined with two external trigger lines: one active-high and one active-low. Each of the three terms (pattern match, high line, low line) can be switched in or out on its own. The enabled terms are ANDed together. A trigger is produced only while capture is armed, and it appears as a single-cycle pulse on the sample clock. The serial chain is frozen while capture is armed.

Top module: `trig_word_match`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `trig_pulse` and `cfg_sdo` are 0. All configuration bits are cleared, so all terms start disabled.
- R2: Each rising edge seen on `cfg_sclk` while `arm` is low shifts `cfg_sdi` into a 67-bit chain. `cfg_sdo` shows the bit that was shifted in 67 edges earlier. The bits come out in the same order they went in.
- R3: The stream is sent most significant bit first in this order. First come three term enables: pattern match, high line, low line. Then come the banks, bank 0 first (bank b covers `samp_word[8b+7:8b]`). For each bank the 8 care bits come first, then the 8 expected-value bits, each byte starting with its bit 7.
- R4: A sample bit whose care bit is 0 does not affect the match. The pattern term is true when every bit whose care bit is 1 equals its expected-value bit.
- R5: `ext_hi` counts as true when it is 1, and `ext_lo` counts as true when it is 0. The trigger condition is the AND of the enabled terms. A disabled term counts as true.
- R6: With all three term enables at 0, `trig_pulse` is never asserted, whatever the inputs are.
- R7: `trig_pulse` is asserted only after a cycle in which `arm` was high. It is high for exactly one cycle each time the armed condition goes from false to true. A condition that stays true produces no further pulses.
- R8: Serial clock edges that arrive while `arm` is high are ignored, and the loaded configuration is unchanged.
- R9: Inputs are sampled at a rising edge of `clk`, and the pulse is visible from that edge until the next one. This is one cycle of latency, and the pulse output does not change before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| arm | input | 1 | Capture armed; enables triggering and freezes the serial chain |
| samp_word | input | 32 | Sampled channel word, four 8-bit banks |
| ext_hi | input | 1 | External trigger, active high |
| ext_lo | input | 1 | External trigger, active low |
| cfg_sclk | input | 1 | Serial configuration clock, rising edge active |
| cfg_sdi | input | 1 | Serial configuration data |
| cfg_sdo | output | 1 | Serial output of the chain's last stage, for chaining |
| trig_pulse | output | 1 | Registered single-cycle trigger pulse |

## Verification
Two events can land in the same cycle: `arm` rising and the qualified condition becoming true. Because the edge detection is gated by `arm`, the pulse must fire on the very first armed cycle. The bench provokes this for every combination of term enables, external line levels and match/miss. It drives the inputs with `arm` low, raises `arm` while they are held, and then expects the arithmetically computed result one edge later and a low output on the edge after. It also sends serial edges while armed and then checks that the triggering still follows the configuration loaded before arming.

// File: rtl/trig_pkg.sv
package trig_pkg;
  localparam int TERM_BITS = 3;

  typedef struct packed {
    logic cmp_on;
    logic hi_on;
    logic lo_on;
  } term_en_t;
endpackage

// File: rtl/trig_cfg_chain.sv
module trig_cfg_chain #(
  parameter int LEN = 67
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           hold,
  input  logic           ser_clk,
  input  logic           ser_din,
  output logic [LEN-1:0] bits,
  output logic           ser_dout
);
  logic sclk_d1, sclk_d2, sdi_d1;
  logic shift_now;

  assign shift_now = sclk_d1 & ~sclk_d2 & ~hold;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d1 <= 1'b0;
      sclk_d2 <= 1'b0;
      sdi_d1  <= 1'b0;
      bits    <= '0;
    end else begin
      sclk_d1 <= ser_clk;
      sclk_d2 <= sclk_d1;
      sdi_d1  <= ser_din;
      if (shift_now) bits <= {bits[LEN-2:0], sdi_d1};
    end
  end

  assign ser_dout = bits[LEN-1];
endmodule

// File: rtl/trig_bank_cmp.sv
module trig_bank_cmp #(
  parameter int W = 8
) (
  input  logic [W-1:0] samp,
  input  logic [W-1:0] care,
  input  logic [W-1:0] want,
  output logic         ok
);
  logic [W-1:0] bit_ok;

  always_comb begin
    for (int i = 0; i < W; i++) bit_ok[i] = ~care[i] | (samp[i] ~^ want[i]);
  end

  assign ok = &bit_ok;
endmodule

// File: rtl/trig_term_and.sv
module trig_term_and
  import trig_pkg::*;
#(
  parameter int BANKS = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             arm,
  input  logic [BANKS-1:0] bank_ok,
  input  term_en_t         en,
  input  logic             ext_hi,
  input  logic             ext_lo,
  output logic             pulse
);
  logic any_on, cond, cond_q;

  always_comb begin
    any_on = en.cmp_on | en.hi_on | en.lo_on;
    cond   = arm & any_on
           & (~en.cmp_on | (&bank_ok))
           & (~en.hi_on  | ext_hi)
           & (~en.lo_on  | ~ext_lo);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cond_q <= 1'b0;
      pulse  <= 1'b0;
    end else begin
      cond_q <= cond;
      pulse  <= cond & ~cond_q;
    end
  end
endmodule

// File: rtl/trig_word_match.sv
module trig_word_match
  import trig_pkg::*;
#(
  parameter int BANKS  = 4,
  parameter int BANK_W = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    arm,
  input  logic [BANKS*BANK_W-1:0] samp_word,
  input  logic                    ext_hi,
  input  logic                    ext_lo,
  input  logic                    cfg_sclk,
  input  logic                    cfg_sdi,
  output logic                    cfg_sdo,
  output logic                    trig_pulse
);
  localparam int CMP_BITS  = 2 * BANKS * BANK_W;
  localparam int CHAIN_LEN = CMP_BITS + TERM_BITS;

  logic [CHAIN_LEN-1:0] cfg_bits;
  logic [BANKS-1:0]     bank_ok;
  term_en_t             term_en;

  trig_cfg_chain #(.LEN(CHAIN_LEN)) u_chain (
    .clk      (clk),
    .rst      (rst),
    .hold     (arm),
    .ser_clk  (cfg_sclk),
    .ser_din  (cfg_sdi),
    .bits     (cfg_bits),
    .ser_dout (cfg_sdo)
  );

  assign term_en = term_en_t'(cfg_bits[CHAIN_LEN-1 -: TERM_BITS]);

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    localparam int CARE_TOP = CMP_BITS - 1 - 2 * BANK_W * b;
    localparam int WANT_TOP = CARE_TOP - BANK_W;
    trig_bank_cmp #(.W(BANK_W)) u_cmp (
      .samp (samp_word[BANK_W*b +: BANK_W]),
      .care (cfg_bits[CARE_TOP -: BANK_W]),
      .want (cfg_bits[WANT_TOP -: BANK_W]),
      .ok   (bank_ok[b])
    );
  end

  trig_term_and #(.BANKS(BANKS)) u_and (
    .clk     (clk),
    .rst     (rst),
    .arm     (arm),
    .bank_ok (bank_ok),
    .en      (term_en),
    .ext_hi  (ext_hi),
    .ext_lo  (ext_lo),
    .pulse   (trig_pulse)
  );
endmodule

// File: rtl/trig_word_match_chk.sv
module trig_word_match_chk #(
  parameter int LEN = 67
) (
  input logic           clk,
  input logic           rst,
  input logic           arm,
  input logic           trig_pulse,
  input logic           cfg_sdo,
  input logic [LEN-1:0] cfg_bits
);
  AST_RESET_QUIET: assert property (@(posedge clk) rst |=> (!trig_pulse && !cfg_sdo)); // R1
  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst) trig_pulse |=> !trig_pulse); // R7
  AST_PULSE_NEEDS_ARM: assert property (@(posedge clk) disable iff (rst) trig_pulse |-> $past(arm)); // R7
  AST_CHAIN_FROZEN: assert property (@(posedge clk) disable iff (rst) $past(arm) |-> $stable(cfg_bits)); // R8
  AST_ALL_OFF_QUIET: assert property (@(posedge clk) disable iff (rst) (cfg_bits[LEN-1 -: 3] == 3'b000) |=> !trig_pulse); // R6
endmodule

bind trig_word_match trig_word_match_chk #(.LEN(CHAIN_LEN)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .arm        (arm),
  .trig_pulse (trig_pulse),
  .cfg_sdo    (cfg_sdo),
  .cfg_bits   (cfg_bits)
);

// File: tb/tb_trig_word_match.sv
`timescale 1ns/1ps
module tb_trig_word_match;
  localparam int LEN = 67;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        arm = 1'b0;
  logic [31:0] samp_word = '0;
  logic        ext_hi = 1'b0;
  logic        ext_lo = 1'b1;
  logic        cfg_sclk = 1'b0;
  logic        cfg_sdi = 1'b0;
  logic        cfg_sdo;
  logic        trig_pulse;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  trig_word_match dut (
    .clk(clk), .rst(rst), .arm(arm), .samp_word(samp_word),
    .ext_hi(ext_hi), .ext_lo(ext_lo), .cfg_sclk(cfg_sclk),
    .cfg_sdi(cfg_sdi), .cfg_sdo(cfg_sdo), .trig_pulse(trig_pulse)
  );

  task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // R3: stream image, index 66 is sent first
  function automatic logic [LEN-1:0] mk_cfg(input logic [2:0] en, input logic [31:0] care, input logic [31:0] want);
    logic [LEN-1:0] v;
    v[66:64] = en;
    for (int b = 0; b < 4; b++) begin
      v[63 - 16*b -: 8] = care[8*b +: 8];
      v[55 - 16*b -: 8] = want[8*b +: 8];
    end
    return v;
  endfunction

  task automatic ser_bit(input logic d);
    @(negedge clk); cfg_sdi = d; cfg_sclk = 1'b1;
    repeat (3) @(negedge clk);
    cfg_sclk = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic load_cfg(input logic [LEN-1:0] v);
    for (int i = LEN - 1; i >= 0; i--) ser_bit(v[i]);
  endtask

  // arm rises together with the condition; pulse expected one edge later
  task automatic try_hit(input logic [31:0] w, input logic hi, input logic lo, input logic exp, input string tag);
    @(negedge clk); arm = 1'b0; samp_word = w; ext_hi = hi; ext_lo = lo;
    @(negedge clk);
    arm = 1'b1;
    #1 check(trig_pulse == 1'b0, "R9 no change before edge", trig_pulse, 0);
    @(negedge clk);
    check(trig_pulse == exp, tag, trig_pulse, exp);
    @(negedge clk);
    check(trig_pulse == 1'b0, "R7 single cycle", trig_pulse, 0);
    arm = 1'b0;
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [LEN-1:0] pat;
    repeat (3) @(negedge clk);
    check(trig_pulse == 1'b0 && cfg_sdo == 1'b0, "R1 reset outputs", {trig_pulse, cfg_sdo}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(trig_pulse == 1'b0 && cfg_sdo == 1'b0, "R1 after reset", {trig_pulse, cfg_sdo}, 0);
    // R6: reset config has all terms off
    try_hit(32'h0, 1'b1, 1'b0, 1'b0, "R6 reset config quiet");

    // R2: chain length and order via serial output
    pat = {3'b101, 64'hC3A5_0F96_7E18_D24B};
    load_cfg(pat);
    for (int i = 0; i < LEN; i++) begin
      check(cfg_sdo == pat[LEN-1-i], "R2 shift-out order", cfg_sdo, pat[LEN-1-i]);
      ser_bit(1'b0);
    end

    // R4 / R3: single care bit sweep over every bank and bit
    for (int i = 0; i < 32; i++) begin
      logic [31:0] want = (i % 2 == 1) ? (32'h1 << i) : 32'h0;
      logic [31:0] rnd  = 32'h6B2D_E519 * (i + 3);
      load_cfg(mk_cfg(3'b100, 32'h1 << i, want));
      try_hit((rnd & ~(32'h1 << i)) | want, 1'b0, 1'b1, 1'b1, "R4 care bit equal");
      try_hit((rnd & ~(32'h1 << i)) | (~want & (32'h1 << i)), 1'b0, 1'b1, 1'b0, "R3 care bit differs");
    end

    // R4: full care, exact word and every single-bit miss
    load_cfg(mk_cfg(3'b100, 32'hFFFF_FFFF, 32'hA5C3_1E77));
    try_hit(32'hA5C3_1E77, 1'b0, 1'b0, 1'b1, "R4 full match");
    for (int i = 0; i < 32; i++)
      try_hit(32'hA5C3_1E77 ^ (32'h1 << i), 1'b0, 1'b0, 1'b0, "R4 one bit off");

    // R5 / R6: every term enable set, line level and match state
    for (int en = 0; en < 8; en++) begin
      load_cfg(mk_cfg(en[2:0], 32'h0000_00FF, 32'h0000_003C));
      for (int hi = 0; hi < 2; hi++)
        for (int lo = 0; lo < 2; lo++)
          for (int m = 0; m < 2; m++) begin
            logic e;
            e = (en != 0) && (!en[2] || m == 1) && (!en[1] || hi == 1) && (!en[0] || lo == 0);
            try_hit(m == 1 ? 32'h5500_003C : 32'h5500_003D, hi[0], lo[0], e,
                    en == 0 ? "R6 all terms off" : "R5 term combination");
          end
    end

    // R7: sustained condition yields one pulse
    load_cfg(mk_cfg(3'b010, 32'h0, 32'h0));
    @(negedge clk); ext_hi = 1'b1; arm = 1'b1;
    @(negedge clk);
    check(trig_pulse == 1'b1, "R7 first pulse", trig_pulse, 1);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      check(trig_pulse == 1'b0, "R7 held condition", trig_pulse, 0);
    end
    arm = 1'b0; ext_hi = 1'b0;

    // R8: serial edges while armed leave config alone
    load_cfg(mk_cfg(3'b100, 32'h0000_00FF, 32'h0000_0011));
    @(negedge clk); arm = 1'b1; samp_word = 32'h0;
    for (int i = 0; i < LEN; i++) ser_bit(1'b1);
    @(negedge clk); arm = 1'b0;
    check(cfg_sdo == 1'b1, "R8 chain head kept", cfg_sdo, 1);
    try_hit(32'h0000_0011, 1'b0, 1'b1, 1'b1, "R8 old pattern still matches");
    try_hit(32'h0000_00FF, 1'b0, 1'b1, 1'b0, "R8 ones not loaded");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule